// File: doc/BRIEF.md
# Serial Line Register Front End

This block gives a processor programmed-I/O access to one asynchronous serial channel over a 16-bit word bus. It claims four word addresses inside a base window chosen by a configuration input. Through them software sees a receive status word, the received character, a transmit status word and a transmit character slot. The serial bit engine sits behind a simple character handshake. It presents each finished character with a one-cycle valid strobe, reports each detected start bit, and takes outgoing characters through a valid/accept pair.

Several status bits change without software action. Reading the received character clears the receive done flag. Loading the transmit slot clears the ready flag until the bit engine takes the character. A start bit cancels a pending reader-advance request. The block raises separate receive and transmit interrupt requests, and it drives a single vector output for them. The receive vector wins when both requests are active. The two vectors share bits 7..3 from a configuration input and differ only in bit 2.

Two small state machines carry the sequencing. The reader machine has the states RDR_IDLE and RDR_ARMED. A write of 1 to receive status bit 0 moves it from RDR_IDLE to RDR_ARMED, and a start bit moves it back to RDR_IDLE. The transmit buffer machine has the states TXB_EMPTY and TXB_FULL. A transmit-slot write moves it from TXB_EMPTY to TXB_FULL, and an accepted handshake moves it back to TXB_EMPTY.

Top module: `slu_regs`

## Requirements
- R1: An access hits only when address bits 15..13 are all one and address bits 12..3 equal `cfg_base`. Address bits 2..1 then select the register: 0 is receive status, 1 is receive data, 2 is transmit status, 3 is transmit data. Address bit 0 is ignored. A read that misses returns 0, and a write that misses changes nothing.
- R2: Receive status bit 7 (done) sets one cycle after an `rx_valid` strobe, and the character then reads from receive data bits 7..0 with bits 15..8 zero. A read of receive data clears done at that clock edge. While `pwr_ok` is low, done is cleared, and this clearing overrides a new character.
- R3: Receive status bit 6 is a read/write interrupt enable, and `bus_init` clears it. `rx_irq` is high exactly while done and this enable are both set.
- R4: Receive status bit 15 reads `(line_dcd | line_cts) & line_dsr`.
- R5: Writing 1 to receive status bit 0 raises `reader_adv` from the next cycle. The bit always reads back 0. `reader_adv` drops in the cycle after an `rx_start` pulse.
- R6: Transmit status bit 7 (ready) is 1 after reset. A transmit-data write while ready is set clears ready, raises `tx_valid`, and puts written bits 7..0 on `tx_char`. One cycle after `tx_accept` is seen with `tx_valid` high, ready is 1 again and `tx_valid` is 0.
- R7: A transmit-data write while ready is 0 is ignored: `tx_char` and ready keep their values.
- R8: Transmit status bit 6 is a read/write interrupt enable, and `bus_init` clears it. `tx_irq` is high exactly while ready and this enable are both set.
- R9: Transmit status bit 0 is a read/write break bit, and `bus_init` clears it. `break_out` follows it.
- R10: The receive vector is `{cfg_vec, 3'b000}` and the transmit vector is `{cfg_vec, 3'b100}`. `irq_vector` shows the receive vector while `rx_irq` is high and the transmit vector otherwise. `irq_req` is the OR of the two requests.
- R11: Every unused status bit reads 0, and a read of transmit data returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| bus_init | input | 1 | Bus initialise, clears enables and break |
| pwr_ok | input | 1 | Power good, low clears receive done |
| bus_addr | input | 16 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| cfg_base | input | 10 | Address bits 12..3 of the register window |
| cfg_vec | input | 5 | Vector bits 7..3 |
| line_dcd | input | 1 | Carrier detect |
| line_cts | input | 1 | Clear to send |
| line_dsr | input | 1 | Data set ready |
| rx_valid | input | 1 | Character complete strobe from bit engine |
| rx_char | input | 8 | Received character |
| rx_start | input | 1 | Start bit detected |
| tx_char | output | 8 | Character offered to bit engine |
| tx_valid | output | 1 | Character offered |
| tx_accept | input | 1 | Bit engine takes the character |
| reader_adv | output | 1 | Reader advance request |
| break_out | output | 1 | Force continuous space on the line |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| irq_req | output | 1 | Either request active |
| irq_vector | output | 8 | Vector of the winning request |

## Verification
The bench sweeps all eight byte offsets of the window, including those with bit 0 set. A decoder that used bit 0 or ignored the top three bits would then show the wrong word or alias into foreign addresses. It runs all 32 vector settings, with and without a receive request alongside a transmit request. A swapped priority or a misplaced bit 2 shows up as the wrong vector. Every character value goes through both data paths. The bench then targets the side effects: done clearing on a data read and on power loss, ready staying clear and the held character not being overwritten by a second write, and the reader request dropping on a start bit. A design that got any of these wrong would drop characters, lose interrupts or corrupt output.

// File: rtl/slu_pkg.sv
package slu_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned BASE_W = 10;
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned VSEL_W = VEC_W - 3;

    typedef enum logic [1:0] {
        REG_RSTAT = 2'd0,
        REG_RBUF  = 2'd1,
        REG_XSTAT = 2'd2,
        REG_XBUF  = 2'd3
    } reg_idx_t;

    typedef enum logic {
        RDR_IDLE,
        RDR_ARMED
    } rdr_state_t;

    typedef enum logic {
        TXB_EMPTY,
        TXB_FULL
    } txb_state_t;
endpackage

// File: rtl/slu_decode.sv
module slu_decode
    import slu_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned BW = BASE_W
) (
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] base,
    input  logic          rd,
    input  logic          wr,
    output logic          hit,
    output reg_idx_t      idx,
    output logic [3:0]    wr_sel,
    output logic          rbuf_rd
);
    localparam int unsigned TOP_W = AW - BW - 3;

    logic unused_addr0;
    assign unused_addr0 = addr[0];

    assign hit = (&addr[AW-1 -: TOP_W]) && (addr[BW+2:3] == base);
    assign idx = reg_idx_t'(addr[2:1]);

    for (genvar i = 0; i < 4; i++) begin : g_wsel
        assign wr_sel[i] = wr && hit && (addr[2:1] == 2'(i));
    end

    assign rbuf_rd = rd && hit && (idx == REG_RBUF);
endmodule

// File: rtl/slu_rx_side.sv
module slu_rx_side
    import slu_pkg::*;
#(
    parameter int unsigned CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_init,
    input  logic          pwr_ok,
    input  logic          csr_wr,
    input  logic          wr_ie,
    input  logic          wr_rdr,
    input  logic          rbuf_rd,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_char,
    input  logic          rx_start,
    input  logic          line_dcd,
    input  logic          line_cts,
    input  logic          line_dsr,
    output logic          done,
    output logic          ie,
    output logic          dset,
    output logic [CW-1:0] rbuf,
    output logic          reader_adv
);
    rdr_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RDR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RDR_IDLE:  if (csr_wr && wr_rdr) state_nx = RDR_ARMED;
            RDR_ARMED: if (rx_start)         state_nx = RDR_IDLE;
        endcase
    end

    assign reader_adv = (state == RDR_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            ie   <= 1'b0;
            rbuf <= '0;
        end else begin
            if (!pwr_ok)       done <= 1'b0;
            else if (rx_valid) done <= 1'b1;
            else if (rbuf_rd)  done <= 1'b0;
            if (rx_valid) rbuf <= rx_char;
            if (bus_init)    ie <= 1'b0;
            else if (csr_wr) ie <= wr_ie;
        end
    end

    assign dset = (line_dcd | line_cts) & line_dsr;

    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rbuf_rd && !rx_valid) |=> !done);
    a_r2_pok_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !done);
    a_r5_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (reader_adv && rx_start) |=> !reader_adv);
    a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> !ie);
endmodule

// File: rtl/slu_tx_side.sv
module slu_tx_side
    import slu_pkg::*;
#(
    parameter int unsigned CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_init,
    input  logic          csr_wr,
    input  logic          buf_wr,
    input  logic          wr_ie,
    input  logic          wr_brk,
    input  logic [CW-1:0] wr_char,
    input  logic          tx_accept,
    output logic          ready,
    output logic          ie,
    output logic          brk,
    output logic [CW-1:0] tx_char,
    output logic          tx_valid
);
    txb_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXB_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TXB_EMPTY: if (buf_wr)    state_nx = TXB_FULL;
            TXB_FULL:  if (tx_accept) state_nx = TXB_EMPTY;
        endcase
    end

    assign ready    = (state == TXB_EMPTY);
    assign tx_valid = (state == TXB_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_char <= '0;
            ie      <= 1'b0;
            brk     <= 1'b0;
        end else begin
            if (buf_wr && state == TXB_EMPTY) tx_char <= wr_char;
            if (bus_init) begin
                ie  <= 1'b0;
                brk <= 1'b0;
            end else if (csr_wr) begin
                ie  <= wr_ie;
                brk <= wr_brk;
            end
        end
    end

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_accept) |=> ($stable(tx_char) && tx_valid));
    a_r6_accept_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_accept) |=> ready);
    a_r9_init_break: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> !brk);
endmodule

// File: rtl/slu_regs.sv
module slu_regs
    import slu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_init,
    input  logic               pwr_ok,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [BASE_W-1:0]  cfg_base,
    input  logic [VSEL_W-1:0]  cfg_vec,
    input  logic               line_dcd,
    input  logic               line_cts,
    input  logic               line_dsr,
    input  logic               rx_valid,
    input  logic [CHAR_W-1:0]  rx_char,
    input  logic               rx_start,
    output logic [CHAR_W-1:0]  tx_char,
    output logic               tx_valid,
    input  logic               tx_accept,
    output logic               reader_adv,
    output logic               break_out,
    output logic               rx_irq,
    output logic               tx_irq,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vector
);
    logic       hit, rbuf_rd;
    reg_idx_t   idx;
    logic [3:0] wr_sel;
    logic       rx_done, rx_ie, rx_dset, tx_ready, tx_ie, tx_brk;
    logic [CHAR_W-1:0] rbuf;
    logic [DATA_W-1:0] rd_word;

    logic [DATA_W-CHAR_W+4:0] unused_wdata;
    assign unused_wdata = {bus_wdata[DATA_W-1:CHAR_W], bus_wdata[5:1]};

    slu_decode #(.AW(ADDR_W), .BW(BASE_W)) u_dec (
        .addr(bus_addr), .base(cfg_base), .rd(bus_rd), .wr(bus_wr),
        .hit(hit), .idx(idx), .wr_sel(wr_sel), .rbuf_rd(rbuf_rd)
    );

    slu_rx_side #(.CW(CHAR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .pwr_ok(pwr_ok),
        .csr_wr(wr_sel[REG_RSTAT]), .wr_ie(bus_wdata[6]), .wr_rdr(bus_wdata[0]),
        .rbuf_rd(rbuf_rd), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_start(rx_start), .line_dcd(line_dcd), .line_cts(line_cts),
        .line_dsr(line_dsr), .done(rx_done), .ie(rx_ie), .dset(rx_dset),
        .rbuf(rbuf), .reader_adv(reader_adv)
    );

    slu_tx_side #(.CW(CHAR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
        .csr_wr(wr_sel[REG_XSTAT]), .buf_wr(wr_sel[REG_XBUF]),
        .wr_ie(bus_wdata[6]), .wr_brk(bus_wdata[0]),
        .wr_char(bus_wdata[CHAR_W-1:0]), .tx_accept(tx_accept),
        .ready(tx_ready), .ie(tx_ie), .brk(tx_brk),
        .tx_char(tx_char), .tx_valid(tx_valid)
    );

    always_comb begin
        rd_word = '0;
        unique case (idx)
            REG_RSTAT: begin
                rd_word[DATA_W-1] = rx_dset;
                rd_word[7]        = rx_done;
                rd_word[6]        = rx_ie;
            end
            REG_RBUF:  rd_word[CHAR_W-1:0] = rbuf;
            REG_XSTAT: begin
                rd_word[7] = tx_ready;
                rd_word[6] = tx_ie;
                rd_word[0] = tx_brk;
            end
            REG_XBUF:  rd_word = '0;
        endcase
    end

    assign bus_rdata  = (bus_rd && hit) ? rd_word : '0;
    assign break_out  = tx_brk;
    assign rx_irq     = rx_done & rx_ie;
    assign tx_irq     = tx_ready & tx_ie;
    assign irq_req    = rx_irq | tx_irq;
    assign irq_vector = {cfg_vec, ~rx_irq, 2'b00};

    a_r10_rx_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && tx_irq) |-> (irq_vector[2] == 1'b0));
    a_r3_init_drops_rx: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> !rx_irq);
    a_r8_init_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |=> !tx_irq);
endmodule

// File: tb/slu_regs_test.sv
`timescale 1ns/1ps
module slu_regs_test;
    logic        clk = 1'b0;
    logic        rst_n, bus_init, pwr_ok, bus_rd, bus_wr;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic [9:0]  cfg_base;
    logic [4:0]  cfg_vec;
    logic        line_dcd, line_cts, line_dsr, rx_valid, rx_start, tx_accept;
    logic [7:0]  rx_char, tx_char, irq_vector;
    logic        tx_valid, reader_adv, break_out, rx_irq, tx_irq, irq_req;

    int checks = 0;
    int fails  = 0;

    localparam logic [15:0] A_RST = 16'hFF70;
    localparam logic [15:0] A_RBF = 16'hFF72;
    localparam logic [15:0] A_XST = 16'hFF74;
    localparam logic [15:0] A_XBF = 16'hFF76;

    always #2.5 clk = ~clk;

    slu_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .pwr_ok(pwr_ok),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_base(cfg_base),
        .cfg_vec(cfg_vec), .line_dcd(line_dcd), .line_cts(line_cts),
        .line_dsr(line_dsr), .rx_valid(rx_valid), .rx_char(rx_char),
        .rx_start(rx_start), .tx_char(tx_char), .tx_valid(tx_valid),
        .tx_accept(tx_accept), .reader_adv(reader_adv), .break_out(break_out),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .irq_req(irq_req),
        .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx_take();
        @(negedge clk);
        tx_accept = 1'b1;
        @(negedge clk);
        tx_accept = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; bus_init = 1'b0; pwr_ok = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0; cfg_base = 10'h3EE; cfg_vec = 5'd6;
        line_dcd = 1'b0; line_cts = 1'b0; line_dsr = 1'b0;
        rx_valid = 1'b0; rx_char = '0; rx_start = 1'b0; tx_accept = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state (R6, R11, R10)
        rd(A_RST, d); check("R11 reset rstat", d, 16'h0000);
        rd(A_XST, d); check("R6 reset ready", d, 16'h0080);
        check("R5 reset reader", {15'd0, reader_adv}, 16'd0);
        check("R6 reset tx_valid", {15'd0, tx_valid}, 16'd0);
        check("R10 reset irq_req", {15'd0, irq_req}, 16'd0);
        check("R10 reset vector", {8'd0, irq_vector}, 16'h0034);

        // enables and break (R3, R8, R9)
        wr(A_RST, 16'hFFFE);
        wr(A_XST, 16'hFF41);
        check("R9 break_out", {15'd0, break_out}, 16'd1);
        check("R8 tx_irq", {15'd0, tx_irq}, 16'd1);

        // offset sweep incl. bit 0 (R1, R11)
        for (int off = 0; off < 8; off++) begin
            logic [15:0] e;
            rd(A_RST + 16'(off), d);
            case (off / 2)
                0: e = 16'h0040;
                1: e = 16'h0000;
                2: e = 16'h00C1;
                default: e = 16'h0000;
            endcase
            check("R1 offset sweep", d, e);
        end
        rd(16'hDF74, d); check("R1 miss top bits", d, 16'h0000);
        rd(16'hFF7C, d); check("R1 miss base", d, 16'h0000);
        wr(16'hDF74, 16'h0000);
        wr(16'hFF64, 16'h0000);
        rd(A_XST, d); check("R1 miss write ignored", d, 16'h00C1);

        // vector sweep (R10)
        for (int s = 0; s < 32; s++) begin
            @(negedge clk); cfg_vec = 5'(s); #1;
            check("R10 tx vector", {8'd0, irq_vector}, 16'(s * 8 + 4));
            check("R10 irq_req", {15'd0, irq_req}, 16'd1);
        end
        rx_put(8'h5A);
        check("R3 rx_irq", {15'd0, rx_irq}, 16'd1);
        for (int s = 0; s < 32; s++) begin
            @(negedge clk); cfg_vec = 5'(s); #1;
            check("R10 rx priority vector", {8'd0, irq_vector}, 16'(s * 8));
        end
        cfg_vec = 5'd6;
        rd(A_RST, d); check("R2 done set", d, 16'h00C0);
        rd(A_RBF, d); check("R2 rbuf data", d, 16'h005A);
        rd(A_RST, d); check("R2 done cleared by read", d, 16'h0040);
        check("R3 rx_irq drop", {15'd0, rx_irq}, 16'd0);

        // character sweep (R2)
        for (int c = 0; c < 256; c++) begin
            rx_put(8'(c));
            rd(A_RBF, d); check("R2 rbuf sweep", d, 16'(c));
            check("R2 done after read", {15'd0, rx_irq}, 16'd0);
        end

        // power-ok clears done (R2)
        rx_put(8'h11);
        @(negedge clk); pwr_ok = 1'b0;
        @(negedge clk); pwr_ok = 1'b1;
        rd(A_RST, d); check("R2 pwr_ok clear", d, 16'h0040);

        // dataset status sweep (R4)
        for (int k = 0; k < 8; k++) begin
            logic ex;
            @(negedge clk);
            line_dcd = k[0]; line_cts = k[1]; line_dsr = k[2];
            ex = (k[0] | k[1]) & k[2];
            rd(A_RST, d); check("R4 dataset", {15'd0, d[15]}, {15'd0, ex});
        end
        line_dcd = 1'b0; line_cts = 1'b0; line_dsr = 1'b0;

        // reader enable (R5)
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        check("R5 idle start", {15'd0, reader_adv}, 16'd0);
        wr(A_RST, 16'h0041);
        check("R5 reader armed", {15'd0, reader_adv}, 16'd1);
        rd(A_RST, d); check("R5 reads zero", d, 16'h0040);
        check("R5 still armed", {15'd0, reader_adv}, 16'd1);
        @(negedge clk); rx_start = 1'b1;
        @(negedge clk); rx_start = 1'b0;
        check("R5 start drops", {15'd0, reader_adv}, 16'd0);

        // transmit (R6, R7, R8, R9)
        wr(A_XST, 16'h0040);
        check("R9 break clear", {15'd0, break_out}, 16'd0);
        wr(A_XBF, 16'h1234);
        check("R6 tx_valid", {15'd0, tx_valid}, 16'd1);
        check("R6 tx_char", {8'd0, tx_char}, 16'h0034);
        check("R8 tx_irq low", {15'd0, tx_irq}, 16'd0);
        rd(A_XST, d); check("R6 ready clear", d, 16'h0040);
        rd(A_XBF, d); check("R11 xbuf reads zero", d, 16'h0000);
        wr(A_XBF, 16'h0055);
        check("R7 ignored write", {8'd0, tx_char}, 16'h0034);
        rd(A_XST, d); check("R7 ready stays clear", d, 16'h0040);
        tx_take();
        check("R6 tx_valid drop", {15'd0, tx_valid}, 16'd0);
        rd(A_XST, d); check("R6 ready set", d, 16'h00C0);
        check("R8 tx_irq", {15'd0, tx_irq}, 16'd1);
        for (int c = 0; c < 256; c++) begin
            wr(A_XBF, 16'hA500 | 16'(c));
            check("R6 tx_char sweep", {7'd0, tx_valid, tx_char}, 16'h0100 | 16'(c));
            tx_take();
        end

        // bus init (R3, R8, R9)
        wr(A_RST, 16'h0040);
        wr(A_XST, 16'h0041);
        @(negedge clk); bus_init = 1'b1;
        @(negedge clk); bus_init = 1'b0;
        rd(A_RST, d); check("R3 init clears rx ie", d, 16'h0000);
        rd(A_XST, d); check("R8 init clears tx ie", d, 16'h0080);
        check("R9 init clears break", {15'd0, break_out}, 16'd0);
        check("R10 no request", {15'd0, irq_req}, 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule